// File: doc/BRIEF.md
# Multi-Bank Level Interrupt Aggregator

This block gathers a set of level-sensitive interrupt lines, grouped into 32-bit words, and routes them to several CPU banks. All banks see the same sources. Each bank has its own mask and its own level interrupt output. The output stays high while any source that is unmasked in that bank is high.

Software reaches the block through a simple single-cycle register bus. The bus carries a bank select and a register entry index. Inside each bank, four register groups are packed back to back: raw levels, current mask, set-mask and clear-mask. Each group has one entry per word, so each group's starting entry scales with the configured word count. A mask can only change through the write-one-to-set and write-one-to-clear entries. Because of this, two agents changing different bits never need a read-modify-write.

The bus decode is combinational. The mask update is a single register stage. No sequencer is involved: each access completes in the cycle it is issued.

Top module: `irqagg_top`

## Requirements
- R1: A read of entry `w` (0 ≤ w < NUM_WORDS) returns the synchronized raw levels of source word `w`, bit i being source 32·w+i, in any valid bank.
- R2: A read of entry `NUM_WORDS+w` returns the addressed bank's current mask for word `w`; a mask bit of 1 means the source is masked.
- R3: A write to entry `2·NUM_WORDS+w` sets every mask bit of word `w` in the selected bank whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to entry `3·NUM_WORDS+w` clears (unmasks) every mask bit of word `w` in the selected bank whose write-data bit is 1 and leaves the others unchanged.
- R5: Mask writes affect only the bank named by the bank select; other banks keep their masks.
- R6: After reset every mask bit in every bank is 1, every interrupt output is 0 and the read data is 0.
- R7: Each bank's interrupt output equals the OR over all words of raw level AND NOT mask, registered one cycle after a mask change takes effect.
- R8: These accesses are ignored: writes to the raw-level and mask entries, writes to entries at or beyond 4·NUM_WORDS, and writes to a bank select at or beyond NUM_CPUS. These reads return 0: reads of the set-mask and clear-mask entries, reads of entries at or beyond 4·NUM_WORDS, and reads with such a bank select.
- R9: A source level change reaches the raw-level register after two clock edges and a bank output after three.
- R10: Read data is registered: it appears one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32·NUM_WORDS | Level interrupt sources |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_bank | input | BANK_W | CPU bank select |
| bus_addr | input | ADDR_W | Register entry index inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CPUS | Per-bank level interrupt output |

## Verification
The bench builds the block with three words and three CPU banks. With a word count that is not a power of two, the group boundaries fall at entries 3, 6 and 9, and the unmapped entries 12 to 15 can be reached with a four-bit index. With three banks, bank select 3 is a legal code that names no bank, so the ignore-and-read-zero rules for both kinds of unmapped access can be exercised.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int WORD_BITS = 32;

    typedef enum logic [2:0] {
        GRP_RAW    = 3'd0,
        GRP_MASKRD = 3'd1,
        GRP_MSET   = 3'd2,
        GRP_MCLR   = 3'd3,
        GRP_NONE   = 3'd4
    } reg_grp_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 5,
    parameter int WSEL_W    = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_grp_e          grp_o,
    output logic [WSEL_W-1:0] word_o
);
    always_comb begin
        grp_o  = GRP_NONE;
        word_o = '0;
        for (int g = 0; g < 4; g++) begin
            if (int'(addr_i) >= g * NUM_WORDS && int'(addr_i) < (g + 1) * NUM_WORDS) begin
                grp_o  = reg_grp_e'(3'(g));
                word_o = WSEL_W'(int'(addr_i) - g * NUM_WORDS);
            end
        end
    end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int WSEL_W    = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 set_en_i,
    input  logic                                 clr_en_i,
    input  logic [WSEL_W-1:0]                    wsel_i,
    input  logic [WORD_BITS-1:0]                 wdata_i,
    input  logic [NUM_WORDS-1:0][WORD_BITS-1:0]  raw_i,
    output logic [NUM_WORDS-1:0][WORD_BITS-1:0]  mask_o,
    output logic                                 irq_o
);
    logic pending;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[w] <= '1;
            end else if (set_en_i && int'(wsel_i) == w) begin
                mask_o[w] <= mask_o[w] | wdata_i;
            end else if (clr_en_i && int'(wsel_i) == w) begin
                mask_o[w] <= mask_o[w] & ~wdata_i;
            end
        end
    end

    assign pending = |(raw_i & ~mask_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pending;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((mask_o[$past(wsel_i)] & $past(wdata_i)) == $past(wdata_i))); // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((mask_o[$past(wsel_i)] & $past(wdata_i)) == '0)); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(mask_o)); // R5
    AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == '0) |=> !irq_o); // R7
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = $clog2(4 * NUM_WORDS),
    parameter int BANK_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_WORDS*WORD_BITS-1:0] src_i,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [BANK_W-1:0]              bus_bank,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [WORD_BITS-1:0]           bus_wdata,
    output logic [WORD_BITS-1:0]           bus_rdata,
    output logic [NUM_CPUS-1:0]            irq_o
);
    localparam int WSEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic [NUM_WORDS-1:0][WORD_BITS-1:0]                raw_q;
    logic [NUM_CPUS-1:0][NUM_WORDS-1:0][WORD_BITS-1:0]  masks;
    reg_grp_e          grp;
    logic [WSEL_W-1:0] wsel;
    logic              bank_ok;

    irqagg_sync #(.WIDTH(NUM_WORDS * WORD_BITS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (raw_q)
    );

    irqagg_decode #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .WSEL_W(WSEL_W)) u_dec (
        .addr_i (bus_addr),
        .grp_o  (grp),
        .word_o (wsel)
    );

    assign bank_ok = int'(bus_bank) < NUM_CPUS;

    for (genvar b = 0; b < NUM_CPUS; b++) begin : g_bank
        logic sel;
        assign sel = bus_wr && int'(bus_bank) == b;
        irqagg_bank #(.NUM_WORDS(NUM_WORDS), .WSEL_W(WSEL_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en_i (sel && grp == GRP_MSET),
            .clr_en_i (sel && grp == GRP_MCLR),
            .wsel_i   (wsel),
            .wdata_i  (bus_wdata),
            .raw_i    (raw_q),
            .mask_o   (masks[b]),
            .irq_o    (irq_o[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (!bank_ok) begin
                bus_rdata <= '0;
            end else begin
                unique case (grp)
                    GRP_RAW:    bus_rdata <= raw_q[wsel];
                    GRP_MASKRD: bus_rdata <= masks[bus_bank][wsel];
                    default:    bus_rdata <= '0;
                endcase
            end
        end
    end

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (grp == GRP_NONE || grp == GRP_MSET || grp == GRP_MCLR)) |=> (bus_rdata == '0)); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/irqagg_top_test.sv
module irqagg_top_test;
    localparam int NW = 3;
    localparam int NC = 3;
    localparam int AW = 4;
    localparam int BW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NW*32-1:0]  src = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [BW-1:0]     bus_bank = '0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC-1:0]     irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] mm [NC][NW];

    always #2 clk = ~clk;

    irqagg_top #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW), .BANK_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_bank(bus_bank), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq(int b);
        logic r = 1'b0;
        for (int w = 0; w < NW; w++) r |= |(src[w*32 +: 32] & ~mm[b][w]);
        return r;
    endfunction

    task automatic wr(int b, int a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_bank = BW'(b); bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (b < NC) begin
            if (a >= 2*NW && a < 3*NW) mm[b][a-2*NW] |= d;
            else if (a >= 3*NW && a < 4*NW) mm[b][a-3*NW] &= ~d;
        end
    endtask

    task automatic rd(int b, int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_bank = BW'(b); bus_addr = AW'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_irqs(string tag);
        for (int b = 0; b < NC; b++) chk(tag, 32'(irq[b]), 32'(exp_irq(b)));
    endtask

    task automatic check_all_masks(string tag);
        logic [31:0] d;
        for (int b = 0; b < NC; b++)
            for (int w = 0; w < NW; w++) begin
                rd(b, NW + w, d);
                chk(tag, d, mm[b][w]);
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, held;
        int seed;
        seed = $urandom(32'd20240611);
        for (int b = 0; b < NC; b++) for (int w = 0; w < NW; w++) mm[b][w] = '1;
        repeat (3) @(negedge clk);
        // R6: reset state
        chk("R6 irq", 32'(irq), 32'h0);
        chk("R6 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        check_all_masks("R6 mask");

        // R1: raw levels read back in every bank
        src = {32'hA5A5_0001, 32'h0000_8000, 32'hDEAD_BEEF};
        settle();
        for (int b = 0; b < NC; b++)
            for (int w = 0; w < NW; w++) begin
                rd(b, w, d);
                chk("R1 raw", d, src[w*32 +: 32]);
            end
        chk("R6 all masked irq", 32'(irq), 32'h0);

        // R4 / R5: clear in bank 1 only
        wr(1, 3*NW + 1, 32'h0000_8000);
        settle();
        check_all_masks("R4 R5 clear");
        check_irqs("R7 after clear");
        chk("R5 other banks quiet", 32'(irq), 32'b010);

        // R3: set back
        wr(1, 2*NW + 1, 32'h0000_C000);
        settle();
        check_all_masks("R3 set");
        chk("R3 irq drops", 32'(irq), 32'h0);

        // R8: ignored writes
        wr(0, 0, 32'hFFFF_FFFF);
        wr(0, NW + 2, 32'h0000_0000);
        wr(2, 4*NW, 32'hFFFF_FFFF);
        wr(3, 3*NW, 32'hFFFF_FFFF);
        check_all_masks("R8 ignored write");
        rd(0, 2*NW, d);      chk("R8 read set entry", d, 32'h0);
        rd(0, 3*NW + 2, d);  chk("R8 read clear entry", d, 32'h0);
        rd(0, 4*NW + 1, d);  chk("R8 read unmapped entry", d, 32'h0);
        rd(3, 0, d);         chk("R8 read bad bank", d, 32'h0);

        // R10: read data holds
        rd(2, 2, held);
        repeat (3) @(negedge clk);
        chk("R10 hold", bus_rdata, held);
        chk("R10 value", held, src[64 +: 32]);

        // R9: exact source latency, bank 0 word 2 bit 31 unmasked
        src = '0;
        wr(0, 3*NW + 2, 32'h8000_0000);
        settle();
        chk("R9 idle", 32'(irq[0]), 32'h0);
        @(negedge clk);
        src[95] = 1'b1;
        @(negedge clk); chk("R9 edge1", 32'(irq[0]), 32'h0);
        @(negedge clk); chk("R9 edge2", 32'(irq[0]), 32'h0);
        @(negedge clk); chk("R9 edge3", 32'(irq[0]), 32'h1);
        src[95] = 1'b0;
        settle();
        chk("R9 release", 32'(irq[0]), 32'h0);

        // Random mix
        for (int i = 0; i < 150; i++) begin
            int op, b, w;
            op = int'($urandom % 4);
            b  = int'($urandom % NC);
            w  = int'($urandom % NW);
            case (op)
                0: for (int k = 0; k < NW; k++) src[k*32 +: 32] = $urandom & $urandom & $urandom;
                1: wr(b, 2*NW + w, $urandom & $urandom);
                2: wr(b, 3*NW + w, $urandom & $urandom & $urandom);
                default: wr(b, int'($urandom % 2) * NW + w, $urandom);
            endcase
            settle();
            check_irqs("R7 random irq");
            rd(b, NW + w, d);
            chk("R2 random mask", d, mm[b][w]);
            rd(b, w, d);
            chk("R1 random raw", d, src[w*32 +: 32]);
        end
        check_all_masks("R5 final masks");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule